// File: doc/BRIEF.md
# Four-Channel Shadowed-Duty PWM Generator

This block drives four PWM outputs from one shared time base. The time base has four counting modes, picked by `mode`. Mode 0 is free-running. Mode 1 is single-shot. Mode 2 is triangular up/down. Mode 3 is triangular up/down with a second duty update at the peak. Software writes a duty value into a per-channel buffer. The comparator does not use that buffer directly. It uses an active register, and the buffer is copied into the active register only at defined points of the count. A duty change therefore never cuts a pulse short or stretches it in the middle of a period. While the time base is stopped, every buffer is copied into its active register on each clock, so the first period after enable uses the latest values.

The time base is a four-state machine:

- **IDLE** holds the timer at 0. It moves to UP when `tb_en` is high.
- **UP** increments the timer.
  - In modes 0 and 1, reaching the period wraps the timer to 0. In mode 0 the state stays in UP. In mode 1 the state goes to DONE.
  - In modes 2 and 3, reaching the period turns the count around. It goes to DOWN, or straight back to UP when the period is 1.
- **DOWN** decrements the timer. It returns to UP as the timer reaches 0.
- **DONE** holds the timer at 0 with the outputs off, as if disabled, until `tb_en` goes low.

From any state, a low `tb_en` forces IDLE. Each output is high while the time base runs and the timer is below that channel's active duty value.

Top module: `pwm_quad_shadow`

## Requirements
- R1: While `rst_n` is low, `timer` reads 0 and all `pwm_out` bits are 0, even with `tb_en` high.
- R2: While `tb_en` is low, `timer` is 0 and every `pwm_out` bit is 0, whatever the duty values. Dropping `tb_en` in mid-run gives that state on the next cycle.
- R3: With `mode`=0, the timer starts at 0 on the first cycle after `tb_en` rises and counts 0,1,...,P, where P is `period`, then wraps to 0. A channel with active duty D is high for exactly D of each P+1 cycles, while the timer is below D.
- R4: An active duty of 0 keeps the output low for the whole period. An active duty greater than P keeps it high for the whole period, in every mode.
- R5: With `mode`=0, a duty written in mid-period does not change the output until the timer wraps from P to 0. From then on the new value applies.
- R6: With `mode`=1, the timer runs 0..P once, then stays at 0 with the outputs low while `tb_en` remains high. Dropping and raising `tb_en` starts a new run.
- R7: With `mode`=2 or 3, the timer counts 0,1,...,P,P-1,...,1 and repeats, which gives a period of 2P cycles. A channel with duty D between 1 and P is high for 2D-1 of those cycles.
- R8: With `mode`=2, the active duty reloads only when the timer is 0 on its way up. A value written during the rising half takes effect only after the next zero.
- R9: With `mode`=3, the active duty reloads both at 0 and at the peak P. A value written during the rising half takes effect from the falling half.
- R10: A duty written while `tb_en` is low governs the first period after enable.
- R11: The channels are independent. A pulse `duty_wr[k]` loads `duty_wdata` into channel k's buffer on the next clock edge and leaves the other channels' buffers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Time-base run enable |
| mode | input | 2 | Counting mode: 0 free-running, 1 single-shot, 2 up/down, 3 up/down with double update |
| period | input | W (8) | Period value P |
| duty_wr | input | NCH (4) | Per-channel buffer write strobes |
| duty_wdata | input | W (8) | Duty value written to each strobed buffer |
| pwm_out | output | NCH (4) | Active-high PWM outputs |
| timer | output | W (8) | Current time-base count |

## Verification
The bench goes after three groups of corner cases.

- **Reload points.** It writes a duty part-way through a period and samples the output at a timer value where the old and new duties disagree. A design that loaded the active register straight from the buffer would glitch in mid-period, breaking R5. A design that took the up/down reload points the wrong way round would swap the falling-half results that tell R8 from R9.
- **Duty extremes.** It runs duty values of 0, exactly P, and above P. An off-by-one compare would leave a one-cycle sliver at zero duty or a one-cycle gap at full duty.
- **Period edges and stopping.** It covers periods of 0 and 1 and the single-shot stop and re-arm. A wrong turnaround at period 1 would stall the triangle. A single-shot that failed to stop would keep pulsing.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_SHOT  = 2'd1,
        MODE_UPDN  = 2'd2,
        MODE_UPDN2 = 2'd3
    } tb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2,
        ST_DONE = 2'd3
    } tb_state_e;
endpackage

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase
    import pwm_quad_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  tb_mode_e     mode,
    input  logic [W-1:0] period,
    output logic [W-1:0] tmr,
    output logic         run,
    output logic         load
);
    localparam logic [W-1:0] ONE = W'(1);

    tb_state_e    st_q, st_d;
    logic [W-1:0] tmr_d;
    logic         edge_mode;
    logic         at_top;

    assign edge_mode = (mode == MODE_FREE) || (mode == MODE_SHOT);
    assign at_top    = (tmr >= period);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            tmr  <= '0;
        end else begin
            st_q <= st_d;
            tmr  <= tmr_d;
        end
    end

    // next-state and next-count
    always_comb begin
        st_d  = st_q;
        tmr_d = tmr;
        if (!en) begin
            st_d  = ST_IDLE;
            tmr_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_UP;
                    tmr_d = '0;
                end
                ST_UP: begin
                    if (edge_mode) begin
                        if (at_top) begin
                            tmr_d = '0;
                            st_d  = (mode == MODE_SHOT) ? ST_DONE : ST_UP;
                        end else begin
                            tmr_d = tmr + ONE;
                        end
                    end else if (period == '0) begin
                        tmr_d = '0;
                    end else if (at_top) begin
                        tmr_d = tmr - ONE;
                        st_d  = (tmr == ONE) ? ST_UP : ST_DOWN;
                    end else begin
                        tmr_d = tmr + ONE;
                    end
                end
                ST_DOWN: begin
                    if (edge_mode || tmr <= ONE) begin
                        st_d  = ST_UP;
                        tmr_d = '0;
                    end else begin
                        tmr_d = tmr - ONE;
                    end
                end
                ST_DONE: begin
                    tmr_d = '0;
                end
                default: begin
                    st_d  = ST_IDLE;
                    tmr_d = '0;
                end
            endcase
        end
    end

    // outputs: run flag and shadow-load strobe
    always_comb begin
        run  = (st_q == ST_UP) || (st_q == ST_DOWN);
        load = !run;
        if (st_q == ST_UP) begin
            unique case (mode)
                MODE_FREE, MODE_SHOT: load = at_top;
                MODE_UPDN:            load = (tmr == '0);
                MODE_UPDN2:           load = (tmr == '0) || at_top;
                default:              load = 1'b0;
            endcase
        end
    end

    AST_IDLE_TMR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tmr == '0)) else $error("timer not cleared after disable"); // R2

    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == ST_UP && mode == MODE_FREE && tmr >= period) |=> (tmr == '0))
        else $error("edge timer did not wrap"); // R3

    AST_UPDN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == ST_UP && !edge_mode && tmr == period && period > ONE)
        |=> (tmr == $past(period) - ONE)) else $error("no turnaround at peak"); // R7

    AST_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == ST_UP && mode == MODE_SHOT && at_top) |=> !run)
        else $error("single shot kept running"); // R6
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] tmr,
    input  logic [W-1:0] period,
    output logic         pwm
);
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr)   buf_q <= wdata;
            if (load) act_q <= buf_q;
        end
    end

    always_comb begin
        pwm = run && (tmr < act_q);
    end

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> !pwm) else $error("output high at zero duty"); // R4

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_q > period && tmr <= period) |-> pwm)
        else $error("output low at full duty"); // R4
endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow
    import pwm_quad_pkg::*;
#(
    parameter int W   = 8,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tb_en,
    input  logic [1:0]     mode,
    input  logic [W-1:0]   period,
    input  logic [NCH-1:0] duty_wr,
    input  logic [W-1:0]   duty_wdata,
    output logic [NCH-1:0] pwm_out,
    output logic [W-1:0]   timer
);
    logic run;
    logic load;

    pwm_quad_timebase #(.W(W)) tb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tb_en),
        .mode   (tb_mode_e'(mode)),
        .period (period),
        .tmr    (timer),
        .run    (run),
        .load   (load)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_quad_chan #(.W(W)) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (duty_wr[g]),
            .wdata  (duty_wdata),
            .load   (load),
            .run    (run),
            .tmr    (timer),
            .period (period),
            .pwm    (pwm_out[g])
        );
    end
endmodule

// File: tb/pwm_quad_shadow_tb_top.sv
module pwm_quad_shadow_tb_top;
    localparam int W = 8;
    localparam int NCH = 4;
    localparam int NV = 7;
    // mode, period, duty ch0..ch3
    localparam int VEC [NV][6] = '{
        '{0, 7, 3, 0, 8, 20},
        '{0, 4, 1, 4, 5, 2},
        '{1, 5, 2, 5, 6, 0},
        '{2, 6, 2, 0, 7, 6},
        '{3, 3, 1, 3, 4, 2},
        '{2, 1, 1, 0, 2, 1},
        '{0, 0, 1, 0, 0, 3}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tb_en = 1'b0;
    logic [1:0]     mode = 2'd0;
    logic [W-1:0]   period = '0;
    logic [NCH-1:0] duty_wr = '0;
    logic [W-1:0]   duty_wdata = '0;
    logic [NCH-1:0] pwm_out;
    logic [W-1:0]   timer;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pwm_quad_shadow #(.W(W), .NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .mode(mode), .period(period),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata), .pwm_out(pwm_out), .timer(timer)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(input int md, input int p, input int d);
        if (md < 2) return (d > p) ? p + 1 : d;
        if (d == 0) return 0;
        if (d > p) return 2 * p;
        return 2 * d - 1;
    endfunction

    task automatic wait_tmr(input int v);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (int'(timer) == v) break;
        end
    endtask

    task automatic write_all(input int d0, input int d1, input int d2, input int d3);
        int dv [4];
        dv = '{d0, d1, d2, d3};
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            duty_wr = NCH'(1) << c;
            duty_wdata = W'(dv[c]);
        end
        @(negedge clk);
        duty_wr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset dominates enable and writes
        tb_en = 1'b1;
        duty_wr = '1;
        duty_wdata = 8'd9;
        repeat (3) @(negedge clk);
        check("R1 timer", int'(timer), 0);
        check("R1 pwm", int'(pwm_out), 0);
        tb_en = 1'b0;
        duty_wr = '0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 timer after release", int'(timer), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int md, p, len;
            int cnt [4];
            string tag;
            md = VEC[v][0];
            p = VEC[v][1];
            tag = (md == 0) ? "R3,R4,R10,R11" : (md == 1) ? "R6,R4,R10,R11" :
                  (md == 2) ? "R7,R4,R10,R11" : "R7,R9,R4,R10,R11";
            @(negedge clk);
            tb_en = 1'b0;
            mode = 2'(md);
            period = W'(p);
            write_all(VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            repeat (3) @(negedge clk);
            check("R2 disabled timer", int'(timer), 0);
            check("R2 disabled pwm", int'(pwm_out), 0);
            tb_en = 1'b1;
            len = (md < 2) ? p + 1 : 2 * p;
            cnt = '{0, 0, 0, 0};
            for (int s = 0; s < len; s++) begin
                @(negedge clk);
                if (s == 0) check({tag, " start timer"}, int'(timer), 0);
                if (s == p) check({tag, " peak timer"}, int'(timer), p);
                for (int c = 0; c < NCH; c++) cnt[c] += int'(pwm_out[c]);
            end
            for (int c = 0; c < NCH; c++)
                check({tag, " high count"}, cnt[c], exp_hi(md, p, VEC[v][2 + c]));
            @(negedge clk);
            check({tag, " next period timer"}, int'(timer), 0);
            if (md == 1) begin
                repeat (4) @(negedge clk);
                check("R6 hold timer", int'(timer), 0);
                check("R6 hold pwm", int'(pwm_out), 0);
                tb_en = 1'b0;
                @(negedge clk);
                tb_en = 1'b1;
                @(negedge clk);
                @(negedge clk);
                check("R6 rearm timer", int'(timer), 1);
            end
        end

        // R5: mid-period write in free-running mode
        @(negedge clk);
        tb_en = 1'b0;
        mode = 2'd0;
        period = 8'd7;
        write_all(2, 2, 2, 2);
        repeat (3) @(negedge clk);
        tb_en = 1'b1;
        wait_tmr(3);
        duty_wr = 4'b0001;
        duty_wdata = 8'd5;
        @(negedge clk);
        duty_wr = '0;
        check("R5 timer", int'(timer), 4);
        check("R5 old duty kept", int'(pwm_out[0]), 0);
        wait_tmr(0);
        wait_tmr(4);
        check("R5 new duty after wrap", int'(pwm_out[0]), 1);
        check("R11 other channel unchanged", int'(pwm_out[1]), 0);

        // R2: disable mid-run
        tb_en = 1'b0;
        @(negedge clk);
        check("R2 mid-run disable timer", int'(timer), 0);
        check("R2 mid-run disable pwm", int'(pwm_out), 0);

        // R8 and R9: write in rising half, observe falling half and next rise
        for (int m = 2; m <= 3; m++) begin
            string rq;
            rq = (m == 2) ? "R8" : "R9";
            @(negedge clk);
            tb_en = 1'b0;
            mode = 2'(m);
            period = 8'd6;
            write_all(2, 2, 2, 2);
            repeat (3) @(negedge clk);
            tb_en = 1'b1;
            wait_tmr(2);
            duty_wr = 4'b0001;
            duty_wdata = 8'd4;
            @(negedge clk);
            duty_wr = '0;
            wait_tmr(6);
            wait_tmr(3);
            check({rq, " falling half"}, int'(pwm_out[0]), (m == 2) ? 0 : 1);
            wait_tmr(0);
            wait_tmr(3);
            check({rq, " next rising half"}, int'(pwm_out[0]), 1);
            check({rq, " other channel"}, int'(pwm_out[1]), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule